// File: doc/BRIEF.md
# Fractional Clock Source Mux Divider

This block produces the clock-enable stream for one peripheral. It takes up to ten single-cycle tick inputs, picks one with a source field held in its control register, and divides the chosen tick rate by a fixed-point divisor. The divisor has an integer part and a fractional part. The output is a one-cycle pulse on `tick_out` for each tick of the divided clock.

Division uses a phase accumulator. Each selected tick adds one unit of 2^FRAC_BITS to the phase. When the phase reaches the divisor, the divisor is subtracted and a pulse is emitted. Over many ticks the output rate is the source rate times 2^FRAC_BITS divided by the divisor, and the pulse spacing between pulses varies by at most one tick. Each instance sets its own integer and fraction widths. With both widths at zero the block is a plain gated selector.

Software writes the control word and the divisor word through two write strobes that share one data bus. Both words can be read back at all times.

Top module: `clkgen_fracdiv`

## Requirements
- R1: While reset is asserted, and after it is released with no write, `ctl_q`, `div_q` and `tick_out` are all zero.
- R2: Control word layout:
  - bits [3:0] hold the source number;
  - bit 4 is the enable;
  - bit 7 is a read-only busy flag that reads the same as the stored enable;
  - every other bit reads 0.
- R3: Divisor word layout:
  - the integer part sits at bits [12+INT_BITS-1:12];
  - the fraction sits at bits [11:12-FRAC_BITS];
  - every other bit reads 0.
  - With the default 4/4 widths the divisor field is bits [15:8], so writing all ones reads back 0x0000FF00.
- R4: Source 0, and source numbers 10 to 15, act as ground. They never produce a pulse, whatever `src_tick[0]` does.
- R5: While the enable bit is 0, `tick_out` stays low.
- R6: When the divisor field is zero (and either width is nonzero), `tick_out` stays low.
- R7: A selected tick sampled at a clock edge adds 2^FRAC_BITS to the phase.
  - If the sum is at least the divisor D, the phase becomes the sum minus D and `tick_out` is high for the following cycle.
  - Otherwise the phase becomes the sum and `tick_out` is low.
  - With the default widths and D = 0x20, exactly every second tick yields a pulse.
- R8: A divisor below 2^FRAC_BITS behaves as exactly 2^FRAC_BITS. Every selected tick then yields a pulse one cycle later.
- R9: In the divided variant, a clock edge with either write strobe high clears the phase to zero and yields no pulse in the next cycle.
- R10: With INT_BITS and FRAC_BITS both zero, every selected tick on an enabled block yields a pulse one cycle later, and `div_q` always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_tick | input | NUM_SRC | One-cycle tick per source; bit 0 is ignored (ground) |
| ctl_we | input | 1 | Write strobe for the control word |
| div_we | input | 1 | Write strobe for the divisor word |
| wdata | input | 32 | Write data shared by both words |
| ctl_q | output | 32 | Control word readback, including busy |
| div_q | output | 32 | Divisor word readback, masked to the field |
| tick_out | output | 1 | Divided output pulse |

## Verification
A corrupted phase accumulator shows up at `tick_out`. The first pulse after a write comes a tick early or late, or the spacing drifts from the expected D/2^FRAC_BITS pattern. The cycle-by-cycle comparison therefore catches it within a few selected ticks of the fault. A wrong source decode or a wrong enable gate shows up sooner still: a pulse appears, or fails to appear, one cycle after the first tick of the wrong source. Register field errors show up in the readback on the cycle after the write.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int NUM_SRC   = 10;
  localparam int SRC_W     = 4;
  localparam int INT_LSB   = 12;
  localparam int EN_BIT    = 4;
  localparam int BUSY_BIT  = 7;
  localparam logic [31:0] CTL_WMASK = 32'h0000_001F;
endpackage

// File: rtl/clkgen_regs.sv
module clkgen_regs
  import clkgen_pkg::*;
#(
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic             div_we,
  input  logic [31:0]      wdata,
  output logic             en,
  output logic [SRC_W-1:0] src,
  output logic [31:0]      ctl_q,
  output logic [31:0]      div_q
);
  localparam int          FLD_W    = INT_BITS + FRAC_BITS;
  localparam int          FLD_LSB  = INT_LSB - FRAC_BITS;
  localparam logic [32:0] FLD_ONES = (33'd1 << FLD_W) - 33'd1;
  localparam logic [31:0] DIV_MASK = 32'(FLD_ONES << FLD_LSB);

  logic [31:0] ctl_raw_q, ctl_raw_d;
  logic [31:0] div_raw_q, div_raw_d;

  always_comb begin
    ctl_raw_d = ctl_raw_q;
    div_raw_d = div_raw_q;
    if (ctl_we) ctl_raw_d = wdata & CTL_WMASK;
    if (div_we) div_raw_d = wdata & DIV_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_raw_q <= '0;
      div_raw_q <= '0;
    end else begin
      ctl_raw_q <= ctl_raw_d;
      div_raw_q <= div_raw_d;
    end
  end

  assign en    = ctl_raw_q[EN_BIT];
  assign src   = ctl_raw_q[SRC_W-1:0];
  assign ctl_q = ctl_raw_q | (32'(ctl_raw_q[EN_BIT]) << BUSY_BIT);
  assign div_q = div_raw_q;

  assert_div_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> ((div_q & ~DIV_MASK) == 32'd0));
endmodule

// File: rtl/clkgen_srcsel.sv
module clkgen_srcsel
  import clkgen_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]     src_tick,
  input  logic [SRC_W-1:0] src,
  output logic             sel_tick
);
  always_comb begin
    sel_tick = 1'b0;
    for (int i = 1; i < N; i++) begin
      if (src == SRC_W'(i)) sel_tick = src_tick[i];
    end
  end
endmodule

// File: rtl/clkgen_phase_div.sv
module clkgen_phase_div #(
  parameter int DW   = 8,
  parameter int FRAC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clr,
  input  logic          tick,
  input  logic [DW-1:0] div_field,
  output logic          pulse
);
  localparam int          AW  = DW + 1;
  localparam logic [AW-1:0] ONE = AW'(1) << FRAC;

  logic [AW-1:0] acc_q, acc_d, div_ext, deff, sum;
  logic          pulse_q, pulse_d;
  logic          active;

  assign div_ext = {1'b0, div_field};
  assign deff    = (div_ext < ONE) ? ONE : div_ext;
  assign sum     = acc_q + ONE;
  assign active  = run && (div_field != '0);

  always_comb begin
    acc_d   = acc_q;
    pulse_d = 1'b0;
    if (clr || !active) begin
      acc_d = '0;
    end else if (tick) begin
      if (sum >= deff) begin
        acc_d   = sum - deff;
        pulse_d = 1'b1;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  assert_phase_below_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < deff);
  assert_zero_div_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_field == '0) |=> !pulse_q);
  assert_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == '0 && !pulse_q));
  assert_clamp_every_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && tick && div_field != '0 && div_ext < ONE) |=> pulse_q);
endmodule

// File: rtl/clkgen_fracdiv.sv
module clkgen_fracdiv
  import clkgen_pkg::*;
#(
  parameter int INT_BITS  = 4,
  parameter int FRAC_BITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               ctl_we,
  input  logic               div_we,
  input  logic [31:0]        wdata,
  output logic [31:0]        ctl_q,
  output logic [31:0]        div_q,
  output logic               tick_out
);
  localparam int DW = INT_BITS + FRAC_BITS;

  logic             en;
  logic [SRC_W-1:0] src;
  logic             sel_tick;

  clkgen_regs #(.INT_BITS(INT_BITS), .FRAC_BITS(FRAC_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .div_we(div_we),
    .wdata(wdata), .en(en), .src(src), .ctl_q(ctl_q), .div_q(div_q)
  );

  clkgen_srcsel #(.N(NUM_SRC)) u_sel (
    .src_tick(src_tick), .src(src), .sel_tick(sel_tick)
  );

  generate
    if (DW == 0) begin : g_pass
      logic pass_q, pass_d;
      assign pass_d = en & sel_tick;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pass_q <= 1'b0;
        else        pass_q <= pass_d;
      end
      assign tick_out = pass_q;

      assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sel_tick) |=> tick_out);
    end else begin : g_div
      logic [DW-1:0] div_field;
      assign div_field = DW'(div_q >> (INT_LSB - FRAC_BITS));
      clkgen_phase_div #(.DW(DW), .FRAC(FRAC_BITS)) u_div (
        .clk(clk), .rst_n(rst_n), .run(en), .clr(ctl_we | div_we),
        .tick(sel_tick), .div_field(div_field), .pulse(tick_out)
      );
    end
  endgenerate

  assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick_out);
  assert_gnd_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0 || src >= SRC_W'(NUM_SRC)) |=> !tick_out);
  assert_pulse_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> $past(sel_tick));
  assert_busy_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_q[BUSY_BIT] == $past(wdata[EN_BIT])));
endmodule

// File: tb/clkgen_fracdiv_tb.sv
module clkgen_fracdiv_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  src_tick;
  logic        ctl_we, div_we;
  logic [31:0] wdata;
  logic [31:0] ctl_q, div_q, ctl_q_pt, div_q_pt;
  logic        tick_out, tick_out_pt;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic       m_en;
  logic [3:0] m_src;
  logic [7:0] m_div;
  int         m_acc;
  logic       e_tick, e_tick_pt;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkgen_fracdiv #(.INT_BITS(4), .FRAC_BITS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ctl_we(ctl_we),
    .div_we(div_we), .wdata(wdata), .ctl_q(ctl_q), .div_q(div_q),
    .tick_out(tick_out)
  );

  clkgen_fracdiv #(.INT_BITS(0), .FRAC_BITS(0)) u_dut_pt (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .ctl_we(ctl_we),
    .div_we(div_we), .wdata(wdata), .ctl_q(ctl_q_pt), .div_q(div_q_pt),
    .tick_out(tick_out_pt)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_ctl(input logic en, input logic [3:0] s);
    return {24'd0, en, 2'b00, en, s};
  endfunction

  function automatic logic sel_of(input logic [3:0] s, input logic [9:0] tk);
    if (s == 4'd0 || s > 4'd9) return 1'b0;
    return tk[s];
  endfunction

  function automatic int deff_of(input logic [7:0] d);
    return (d < 8'd16) ? 16 : int'(d);
  endfunction

  // one clock: drive now (after negedge), update model at posedge, check at negedge
  task automatic cycle(input string tag, input logic wc, input logic wd,
                       input logic [31:0] wv, input logic [9:0] tk);
    logic sel;
    int   s;
    ctl_we = wc; div_we = wd; wdata = wv; src_tick = tk;
    @(posedge clk);
    sel = sel_of(m_src, tk);
    e_tick_pt = m_en && sel;
    e_tick = 1'b0;
    if (wc || wd || !m_en || m_div == 8'd0) begin
      m_acc = 0;
    end else if (sel) begin
      s = m_acc + 16;
      if (s >= deff_of(m_div)) begin
        m_acc = s - deff_of(m_div);
        e_tick = 1'b1;
      end else begin
        m_acc = s;
      end
    end
    if (wc) begin m_en = wv[4]; m_src = wv[3:0]; end
    if (wd) m_div = wv[15:8];
    @(negedge clk);
    check(tag, 32'(tick_out), 32'(e_tick));
    check({tag, "/R10"}, 32'(tick_out_pt), 32'(e_tick_pt));
    if (wc) begin
      check("R2", ctl_q, exp_ctl(m_en, m_src));
      check("R2", ctl_q_pt, exp_ctl(m_en, m_src));
    end
    if (wd) begin
      check("R3", div_q, {16'd0, m_div, 8'd0});
      check("R10", div_q_pt, 32'd0);
    end
  endtask

  task automatic idle(input string tag, input int n, input logic [9:0] tk);
    for (int i = 0; i < n; i++) cycle(tag, 1'b0, 1'b0, 32'd0, tk);
  endtask

  function automatic logic [9:0] rnd_ticks(input int dens);
    logic [9:0] v;
    for (int b = 0; b < 10; b++) v[b] = (($urandom % 100) < dens);
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; ctl_we = 0; div_we = 0; wdata = '0; src_tick = '0;
    m_en = 0; m_src = 0; m_div = 0; m_acc = 0;
    repeat (3) @(negedge clk);
    check("R1", ctl_q, 32'd0);
    check("R1", div_q, 32'd0);
    check("R1", 32'(tick_out), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", ctl_q, 32'd0);
    check("R1", div_q, 32'd0);

    // R2 layout with all bits written; source 15 acts as ground (R4)
    cycle("R2", 1'b1, 1'b0, 32'hFFFF_FFFF, 10'h000);
    check("R2", ctl_q, 32'h0000_009F);
    cycle("R3", 1'b0, 1'b1, 32'hFFFF_FFFF, 10'h000);
    check("R3", div_q, 32'h0000_FF00);
    idle("R4", 20, 10'h3FF);
    // source 0 with its tick pin held high
    cycle("R4", 1'b1, 1'b0, 32'h0000_0010, 10'h001);
    idle("R4", 20, 10'h001);
    // zero divisor on source 1
    cycle("R6", 1'b1, 1'b0, 32'h0000_0011, 10'h000);
    cycle("R6", 1'b0, 1'b1, 32'h0000_0000, 10'h002);
    idle("R6", 20, 10'h002);
    // clamp: divisor 5 (< 16)
    cycle("R8", 1'b0, 1'b1, 32'h0000_0500, 10'h002);
    idle("R8", 20, 10'h002);
    idle("R8", 20, 10'h00A);
    // divisor 2.0: every other tick
    cycle("R7", 1'b0, 1'b1, 32'h0000_2000, 10'h000);
    idle("R7", 30, 10'h002);
    // divisor 1.5
    cycle("R7", 1'b0, 1'b1, 32'h0000_1800, 10'h000);
    idle("R7", 30, 10'h002);
    // write mid-stream clears phase
    idle("R9", 3, 10'h002);
    cycle("R9", 1'b0, 1'b1, 32'h0000_1800, 10'h002);
    idle("R9", 10, 10'h002);
    cycle("R9", 1'b1, 1'b0, 32'h0000_0013, 10'h008);
    idle("R9", 10, 10'h008);
    // disabled
    cycle("R5", 1'b1, 1'b0, 32'h0000_0003, 10'h008);
    idle("R5", 20, 10'h3FF);

    // constrained random episodes
    for (int ep = 0; ep < 80; ep++) begin
      logic [31:0] c, d;
      int dens;
      c = {27'd0, (($urandom % 5) != 0), 4'($urandom % 16)};
      d = {16'd0, 8'($urandom % 64), 8'($urandom)};
      if (($urandom % 8) == 0) d[15:8] = 8'd0;
      dens = 10 + int'($urandom % 90);
      cycle("R7", 1'b1, 1'b0, c, rnd_ticks(dens));
      cycle("R7", 1'b0, 1'b1, d, rnd_ticks(dens));
      for (int k = 0; k < 120; k++) begin
        if (($urandom % 97) == 0)
          cycle("R9", 1'b0, 1'b1, d, rnd_ticks(dens));
        else
          cycle("R7", 1'b0, 1'b0, 32'd0, rnd_ticks(dens));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule